// File: doc/BRIEF.md
# Dual-Issue Register Rename Table

This block keeps, for every architected register, a record of where its newest value lives. The value is either already in the architected register file, or it will come from an in-flight instruction identified by its reorder-buffer tag. Each cycle a front end offers up to two instructions, oldest first. Each instruction carries two source register numbers, a destination register number and a flag that says whether it writes its destination. The block reports the location of all four sources in the same cycle. It takes as many instructions, in order, as the free-resource count allows. Each accepted writer claims the reorder-buffer tag given to it, so the older instruction gets the tail and the younger gets tail plus one.

The younger instruction may read a register that the older one in the same group writes. In that case the younger instruction's source must point at the older instruction's new tag, not at the stale table entry. At commit, the reorder buffer presents the register and tag of the retiring producer. The entry returns to the architected file only if that tag is still the newest producer of the register. When a rename and a commit-clear of the same register fall in the same cycle, the rename is kept.

Top module: `dual_rename_table`

## Requirements
- R1: After reset, every register reads as held in the architected file (busy 0, tag 0).
- R2: A source whose register is mapped to the architected file reports busy 0 and tag 0. A source whose register is mapped to an in-flight producer reports busy 1 and that producer's tag. Source ports are indexed 0 = slot 0 first source, 1 = slot 0 second source, 2 = slot 1 first source, 3 = slot 1 second source.
- R3: The accepted count is 1 when slot 0 is valid and free_slots is at least 1. It is 2 when, in addition, slot 1 is valid and free_slots is at least 2. In every other case it is 0, including a valid slot 1 behind an invalid slot 0.
- R4: An accepted writer in slot 0 maps its destination to tail_tag. An accepted writer in slot 1 maps its destination to tail_tag+1, modulo the buffer depth. The new mapping is visible to lookups from the next cycle.
- R5: When slot 0 is valid and writes, any slot 1 source equal to slot 0's destination reports busy 1 with tag tail_tag, whatever the table holds.
- R6: When both accepted instructions write the same register, that register ends up mapped to tail_tag+1.
- R7: A commit whose tag matches the register's current mapping returns the register to the architected file from the next cycle.
- R8: A commit whose tag no longer matches the register's mapping leaves the mapping unchanged.
- R9: When a register is renamed in the same cycle that a matching commit would clear it, the new mapping is kept.
- R10: An instruction that is not accepted leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in0_valid | input | 1 | Slot 0 (older) carries an instruction |
| in0_wr | input | 1 | Slot 0 writes a destination register |
| in0_src_a | input | AREG_W | Slot 0 first source register |
| in0_src_b | input | AREG_W | Slot 0 second source register |
| in0_dst | input | AREG_W | Slot 0 destination register |
| in1_valid | input | 1 | Slot 1 (younger) carries an instruction |
| in1_wr | input | 1 | Slot 1 writes a destination register |
| in1_src_a | input | AREG_W | Slot 1 first source register |
| in1_src_b | input | AREG_W | Slot 1 second source register |
| in1_dst | input | AREG_W | Slot 1 destination register |
| free_slots | input | 2 | Resource entries free this cycle, saturating at 3 |
| tail_tag | input | TAG_W | Tag of the next free reorder-buffer entry |
| commit_valid | input | 1 | A producer retires this cycle |
| commit_areg | input | AREG_W | Destination register of the retiring producer |
| commit_tag | input | TAG_W | Tag of the retiring producer |
| src_busy | output | 4 | Per source: 1 = value pending from a producer |
| src_tag | output | 4 x TAG_W | Per source: producer tag, 0 when not busy |
| num_accepted | output | 2 | Instructions renamed this cycle (0 to 2) |

## Verification
The bench builds the block with eight architected registers and an eight-entry buffer, so tags are three bits wide. With a tag that narrow, a group issued at tail 7 gives the younger instruction tag 0, which exercises the wrap of tail+1. Eight registers are few enough that stale commits, same-register double writes and rename-versus-commit collisions all land on registers that later vectors read back through the source ports.

// File: rtl/rat_pkg.sv
package rat_pkg;

    // Number of source operands reported per cycle (two slots, two sources each).
    localparam int SRC_PER_SLOT = 2;
    localparam int SLOTS        = 2;
    localparam int NUM_SRC      = SRC_PER_SLOT * SLOTS;

    // Accepted-count encoding.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_ONE  = 2'd1,
        ACC_TWO  = 2'd2
    } acc_cnt_e;

endpackage

// File: rtl/rat_accept.sv
module rat_accept
    import rat_pkg::*;
(
    input  logic       in0_valid,
    input  logic       in1_valid,
    input  logic [1:0] free_slots,
    output logic       take0,
    output logic       take1,
    output acc_cnt_e   count
);

    always_comb begin
        take0 = in0_valid && (free_slots != 2'd0);
        take1 = take0 && in1_valid && (free_slots >= 2'd2);
        if (take1) begin
            count = ACC_TWO;
        end else if (take0) begin
            count = ACC_ONE;
        end else begin
            count = ACC_NONE;
        end
    end

endmodule

// File: rtl/rat_src_lookup.sv
module rat_src_lookup #(
    parameter int NUM_AREGS = 32,
    parameter int TAG_W     = 6,
    localparam int AREG_W   = $clog2(NUM_AREGS)
) (
    input  logic [NUM_AREGS-1:0]            map_busy,
    input  logic [NUM_AREGS-1:0][TAG_W-1:0] map_tag,
    input  logic [AREG_W-1:0]               src,
    input  logic                            byp_en,
    input  logic [AREG_W-1:0]               byp_dst,
    input  logic [TAG_W-1:0]                byp_tag,
    output logic                            busy,
    output logic [TAG_W-1:0]                tag
);

    always_comb begin
        if (byp_en && (src == byp_dst)) begin
            busy = 1'b1;
            tag  = byp_tag;
        end else begin
            busy = map_busy[src];
            tag  = map_busy[src] ? map_tag[src] : '0;
        end
    end

endmodule

// File: rtl/rat_table.sv
module rat_table #(
    parameter int NUM_AREGS = 32,
    parameter int TAG_W     = 6,
    localparam int AREG_W   = $clog2(NUM_AREGS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr0_en,
    input  logic [AREG_W-1:0]               wr0_reg,
    input  logic [TAG_W-1:0]                wr0_tag,
    input  logic                            wr1_en,
    input  logic [AREG_W-1:0]               wr1_reg,
    input  logic [TAG_W-1:0]                wr1_tag,
    input  logic                            clr_en,
    input  logic [AREG_W-1:0]               clr_reg,
    input  logic [TAG_W-1:0]                clr_tag,
    output logic [NUM_AREGS-1:0]            map_busy,
    output logic [NUM_AREGS-1:0][TAG_W-1:0] map_tag
);

    typedef struct packed {
        logic [NUM_AREGS-1:0]            busy;
        logic [NUM_AREGS-1:0][TAG_W-1:0] tag;
    } table_t;

    table_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        for (int r = 0; r < NUM_AREGS; r++) begin
            // The younger writer takes priority, then the older one, then a clear.
            if (wr1_en && (wr1_reg == AREG_W'(r))) begin
                tbl_d.busy[r] = 1'b1;
                tbl_d.tag[r]  = wr1_tag;
            end else if (wr0_en && (wr0_reg == AREG_W'(r))) begin
                tbl_d.busy[r] = 1'b1;
                tbl_d.tag[r]  = wr0_tag;
            end else if (clr_en && (clr_reg == AREG_W'(r)) &&
                         tbl_q.busy[r] && (tbl_q.tag[r] == clr_tag)) begin
                tbl_d.busy[r] = 1'b0;
                tbl_d.tag[r]  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign map_busy = tbl_q.busy;
    assign map_tag  = tbl_q.tag;

endmodule

// File: rtl/dual_rename_table.sv
module dual_rename_table
    import rat_pkg::*;
#(
    parameter int NUM_AREGS = 32,
    parameter int ROB_DEPTH = 64,
    localparam int AREG_W   = $clog2(NUM_AREGS),
    localparam int TAG_W    = $clog2(ROB_DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in0_valid,
    input  logic                          in0_wr,
    input  logic [AREG_W-1:0]             in0_src_a,
    input  logic [AREG_W-1:0]             in0_src_b,
    input  logic [AREG_W-1:0]             in0_dst,
    input  logic                          in1_valid,
    input  logic                          in1_wr,
    input  logic [AREG_W-1:0]             in1_src_a,
    input  logic [AREG_W-1:0]             in1_src_b,
    input  logic [AREG_W-1:0]             in1_dst,
    input  logic [1:0]                    free_slots,
    input  logic [TAG_W-1:0]              tail_tag,
    input  logic                          commit_valid,
    input  logic [AREG_W-1:0]             commit_areg,
    input  logic [TAG_W-1:0]              commit_tag,
    output logic [NUM_SRC-1:0]            src_busy,
    output logic [NUM_SRC-1:0][TAG_W-1:0] src_tag,
    output logic [1:0]                    num_accepted
);

    logic                            take0, take1;
    acc_cnt_e                        acc_cnt;
    logic [TAG_W-1:0]                tag_next;
    logic [NUM_AREGS-1:0]            map_busy;
    logic [NUM_AREGS-1:0][TAG_W-1:0] map_tag;
    logic [NUM_SRC-1:0][AREG_W-1:0]  src_sel;
    logic                            grp_byp;

    assign tag_next = tail_tag + TAG_W'(1);
    assign grp_byp  = in0_valid && in0_wr;
    assign src_sel  = {in1_src_b, in1_src_a, in0_src_b, in0_src_a};

    rat_accept u_accept (
        .in0_valid  (in0_valid),
        .in1_valid  (in1_valid),
        .free_slots (free_slots),
        .take0      (take0),
        .take1      (take1),
        .count      (acc_cnt)
    );

    assign num_accepted = acc_cnt;

    rat_table #(
        .NUM_AREGS (NUM_AREGS),
        .TAG_W     (TAG_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr0_en   (take0 && in0_wr),
        .wr0_reg  (in0_dst),
        .wr0_tag  (tail_tag),
        .wr1_en   (take1 && in1_wr),
        .wr1_reg  (in1_dst),
        .wr1_tag  (tag_next),
        .clr_en   (commit_valid),
        .clr_reg  (commit_areg),
        .clr_tag  (commit_tag),
        .map_busy (map_busy),
        .map_tag  (map_tag)
    );

    // Sources 0..1 belong to slot 0 (no bypass); 2..3 to slot 1 (bypass from slot 0).
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        rat_src_lookup #(
            .NUM_AREGS (NUM_AREGS),
            .TAG_W     (TAG_W)
        ) u_lookup (
            .map_busy (map_busy),
            .map_tag  (map_tag),
            .src      (src_sel[s]),
            .byp_en   ((s >= SRC_PER_SLOT) ? grp_byp : 1'b0),
            .byp_dst  (in0_dst),
            .byp_tag  (tail_tag),
            .busy     (src_busy[s]),
            .tag      (src_tag[s])
        );
    end

endmodule

// File: rtl/rat_checker.sv
module rat_checker #(
    parameter int NUM_AREGS = 32,
    parameter int ROB_DEPTH = 64,
    localparam int AREG_W   = $clog2(NUM_AREGS),
    localparam int TAG_W    = $clog2(ROB_DEPTH)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            in0_valid,
    input logic                            in0_wr,
    input logic [AREG_W-1:0]               in0_dst,
    input logic                            in1_valid,
    input logic                            in1_wr,
    input logic [AREG_W-1:0]               in1_src_a,
    input logic [AREG_W-1:0]               in1_dst,
    input logic [1:0]                      free_slots,
    input logic [TAG_W-1:0]                tail_tag,
    input logic                            commit_valid,
    input logic [AREG_W-1:0]               commit_areg,
    input logic [TAG_W-1:0]                commit_tag,
    input logic [3:0]                      src_busy,
    input logic [3:0][TAG_W-1:0]           src_tag,
    input logic [1:0]                      num_accepted,
    input logic [NUM_AREGS-1:0]            map_busy,
    input logic [NUM_AREGS-1:0][TAG_W-1:0] map_tag
);

    p_accept_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        num_accepted <= free_slots);

    p_in_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (num_accepted != 2'd0) |-> (in0_valid && ((num_accepted != 2'd2) || in1_valid)));

    p_group_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in0_valid && in0_wr && (in1_src_a == in0_dst)) |->
            (src_busy[2] && (src_tag[2] == tail_tag)));

    p_first_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((num_accepted != 2'd0) && in0_wr &&
         !((num_accepted == 2'd2) && in1_wr && (in1_dst == in0_dst))) |=>
            (map_busy[$past(in0_dst)] && (map_tag[$past(in0_dst)] == $past(tail_tag))));

    p_second_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((num_accepted == 2'd2) && in1_wr) |=>
            (map_busy[$past(in1_dst)] &&
             (map_tag[$past(in1_dst)] == ($past(tail_tag) + TAG_W'(1)))));

    p_commit_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((num_accepted == 2'd0) && commit_valid && map_busy[commit_areg] &&
         (map_tag[commit_areg] == commit_tag)) |=> !map_busy[$past(commit_areg)]);

    p_stale_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((num_accepted == 2'd0) && commit_valid && map_busy[commit_areg] &&
         (map_tag[commit_areg] != commit_tag)) |=>
            (map_busy[$past(commit_areg)] &&
             (map_tag[$past(commit_areg)] == $past(map_tag[commit_areg]))));

endmodule

bind dual_rename_table rat_checker #(
    .NUM_AREGS (NUM_AREGS),
    .ROB_DEPTH (ROB_DEPTH)
) u_rat_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in0_valid    (in0_valid),
    .in0_wr       (in0_wr),
    .in0_dst      (in0_dst),
    .in1_valid    (in1_valid),
    .in1_wr       (in1_wr),
    .in1_src_a    (in1_src_a),
    .in1_dst      (in1_dst),
    .free_slots   (free_slots),
    .tail_tag     (tail_tag),
    .commit_valid (commit_valid),
    .commit_areg  (commit_areg),
    .commit_tag   (commit_tag),
    .src_busy     (src_busy),
    .src_tag      (src_tag),
    .num_accepted (num_accepted),
    .map_busy     (map_busy),
    .map_tag      (map_tag)
);

// File: tb/dual_rename_table_bench.sv
module dual_rename_table_bench;

    localparam int NREG = 8;
    localparam int DEPTH = 8;
    localparam int AW = 3;
    localparam int TW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in0_valid = 0, in0_wr = 0, in1_valid = 0, in1_wr = 0;
    logic [AW-1:0] in0_src_a = 0, in0_src_b = 0, in0_dst = 0;
    logic [AW-1:0] in1_src_a = 0, in1_src_b = 0, in1_dst = 0;
    logic [1:0] free_slots = 0;
    logic [TW-1:0] tail_tag = 0;
    logic commit_valid = 0;
    logic [AW-1:0] commit_areg = 0;
    logic [TW-1:0] commit_tag = 0;
    logic [3:0] src_busy;
    logic [3:0][TW-1:0] src_tag;
    logic [1:0] num_accepted;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dual_rename_table #(.NUM_AREGS(NREG), .ROB_DEPTH(DEPTH)) u_dual_rename_table (
        .clk(clk), .rst_n(rst_n),
        .in0_valid(in0_valid), .in0_wr(in0_wr), .in0_src_a(in0_src_a),
        .in0_src_b(in0_src_b), .in0_dst(in0_dst),
        .in1_valid(in1_valid), .in1_wr(in1_wr), .in1_src_a(in1_src_a),
        .in1_src_b(in1_src_b), .in1_dst(in1_dst),
        .free_slots(free_slots), .tail_tag(tail_tag),
        .commit_valid(commit_valid), .commit_areg(commit_areg), .commit_tag(commit_tag),
        .src_busy(src_busy), .src_tag(src_tag), .num_accepted(num_accepted)
    );

    typedef struct packed {
        logic v0; logic w0; logic [2:0] a0; logic [2:0] b0; logic [2:0] d0;
        logic v1; logic w1; logic [2:0] a1; logic [2:0] b1; logic [2:0] d1;
        logic [1:0] free; logic [2:0] tail;
        logic cv; logic [2:0] creg; logic [2:0] ctag;
        logic [1:0] ecnt; logic [3:0] ebusy; logic [11:0] etag;  // etag = {t3,t2,t1,t0}
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        // V0: R5 bypass r3, R4 r3->0 r5->1
        '{1'b1,1'b1,3'd1,3'd2,3'd3, 1'b1,1'b1,3'd3,3'd4,3'd5, 2'd2,3'd0, 1'b0,3'd0,3'd0,
          2'd2,4'b0100,{3'd0,3'd0,3'd0,3'd0}},
        // V1: R3 one accepted, R2 lookups, R5 bypass r3 tag 2; r3->2, r6 untouched (R10)
        '{1'b1,1'b1,3'd3,3'd5,3'd3, 1'b1,1'b1,3'd3,3'd6,3'd6, 2'd1,3'd2, 1'b0,3'd0,3'd0,
          2'd1,4'b0111,{3'd0,3'd2,3'd1,3'd0}},
        // V2: R3 slot1 behind invalid slot0 -> 0
        '{1'b0,1'b0,3'd0,3'd0,3'd0, 1'b1,1'b1,3'd3,3'd5,3'd7, 2'd2,3'd3, 1'b0,3'd0,3'd0,
          2'd0,4'b1100,{3'd1,3'd2,3'd0,3'd0}},
        // V3: R8 stale commit of r3 tag0
        '{1'b0,1'b0,3'd3,3'd5,3'd0, 1'b0,1'b0,3'd0,3'd0,3'd0, 2'd2,3'd3, 1'b1,3'd3,3'd0,
          2'd0,4'b0011,{3'd0,3'd0,3'd1,3'd2}},
        // V4: R8 r3 still tag2; R7 commit r5 tag1
        '{1'b0,1'b0,3'd3,3'd5,3'd0, 1'b0,1'b0,3'd0,3'd0,3'd0, 2'd2,3'd3, 1'b1,3'd5,3'd1,
          2'd0,4'b0011,{3'd0,3'd0,3'd1,3'd2}},
        // V5: R7 r5 cleared; R6 both write r4 at tail 7; R7 commit r3 tag2
        '{1'b1,1'b1,3'd5,3'd3,3'd4, 1'b1,1'b1,3'd4,3'd0,3'd4, 2'd3,3'd7, 1'b1,3'd3,3'd2,
          2'd2,4'b0110,{3'd0,3'd7,3'd2,3'd0}},
        // V6: R6/R4 r4 tag0 (wrap), R7 r3 cleared; R9 rename r4 at tail1 with commit r4 tag0
        '{1'b1,1'b1,3'd4,3'd3,3'd4, 1'b1,1'b1,3'd4,3'd1,3'd2, 2'd1,3'd1, 1'b1,3'd4,3'd0,
          2'd1,4'b0101,{3'd0,3'd1,3'd0,3'd0}},
        // V7: R9 r4 keeps tag1; R10 r6 never renamed
        '{1'b0,1'b0,3'd4,3'd6,3'd0, 1'b0,1'b0,3'd5,3'd2,3'd0, 2'd0,3'd2, 1'b0,3'd0,3'd0,
          2'd0,4'b0001,{3'd0,3'd0,3'd0,3'd1}}
    };

    function automatic string vec_reqs(int i);
        case (i)
            0: return "R4 R5";
            1: return "R3 R5 R2";
            2: return "R3 R2";
            3: return "R8";
            4: return "R8 R7";
            5: return "R7 R6 R5";
            6: return "R6 R4 R7 R9";
            default: return "R9 R10";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in0_valid = v.v0; in0_wr = v.w0; in0_src_a = v.a0; in0_src_b = v.b0; in0_dst = v.d0;
        in1_valid = v.v1; in1_wr = v.w1; in1_src_a = v.a1; in1_src_b = v.b1; in1_dst = v.d1;
        free_slots = v.free; tail_tag = v.tail;
        commit_valid = v.cv; commit_areg = v.creg; commit_tag = v.ctag;
    endtask

    task automatic idle();
        in0_valid = 0; in0_wr = 0; in1_valid = 0; in1_wr = 0;
        free_slots = 0; commit_valid = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads as in the architected file after reset.
        for (int r = 0; r < NREG; r += 2) begin
            @(negedge clk);
            idle();
            in0_src_a = AW'(r); in0_src_b = AW'(r + 1);
            in1_src_a = AW'(r); in1_src_b = AW'(r + 1);
            #1;
            chk("R1 busy", int'(src_busy), 0);
            chk("R1 tag", int'(src_tag), 0);
        end

        // R3: free_slots of 0 blocks both slots.
        @(negedge clk);
        idle();
        in0_valid = 1; in1_valid = 1; free_slots = 2'd0;
        #1;
        chk("R3 no free", int'(num_accepted), 0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #1;
            chk($sformatf("%s v%0d count", vec_reqs(i), i), int'(num_accepted), int'(VECS[i].ecnt));
            chk($sformatf("%s v%0d busy", vec_reqs(i), i), int'(src_busy), int'(VECS[i].ebusy));
            chk($sformatf("%s v%0d tag", vec_reqs(i), i), int'(src_tag), int'(VECS[i].etag));
        end

        // R1: a reset in mid-run returns r4 to the architected file.
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        in0_src_a = 3'd4; in1_src_b = 3'd4;
        #1;
        chk("R1 mid-run reset busy", int'(src_busy), 0);

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule